// File: doc/BRIEF.md
# Banked Register File with Exchange Commands

This block is the register storage of an 8-bit processor core. It holds two copies of the accumulator/flags pair and two copies of the BC, DE and HL pairs. It also holds single copies of the stack pointer and the two index registers. At any moment one copy of each banked group is visible. The other copy is hidden, and no read or write port can address it.

Two exchange opcodes, decoded inside the block, change which copy is visible. Each exchange flips a one-bit bank select, so no register data moves. One opcode flips the select for the accumulator/flags pair only. The other flips the select for BC, DE and HL together.

The core reads registers through a byte port and a word port, both combinational. It writes through one registered port that takes either a byte or a word. An exchange and a write may be issued in the same cycle.

Top module: `dual_bank_regfile`

## Requirements
- R1: After reset both bank selects are clear, every register in both copies holds all ones, and every byte read returns FFh and every valid word read returns FFFFh.
- R2: Byte codes are B=0, C=1, D=2, E=3, H=4, L=5, F=6, A=7. Word codes are BC=0, DE=1, HL=2, AF=3, SP=4, IX=5, IY=6. Word code 7 reads as zero. In each pair the first letter is the high byte, so B is bits 15:8 of BC and A is bits 15:8 of AF.
- R3: A byte write (wr_word=0) changes only the addressed byte, using wr_data[7:0]. A word write (wr_word=1) replaces the whole addressed pair. Either write becomes visible on the read ports after the next rising clock edge. A word write to code 7 changes nothing.
- R4: An exchange with opcode 08h flips only the accumulator/flags select. A second such exchange brings the earlier contents back.
- R5: An exchange with opcode D9h flips the BC/DE/HL select. All three pairs switch together.
- R6: Any other opcode, or any opcode presented while xchg_valid is low, leaves both selects unchanged.
- R7: Writes reach only the visible copy. The hidden copy keeps its contents until an exchange makes it visible again.
- R8: SP, IX and IY are not affected by either exchange.
- R9: When a write and an exchange occur in the same cycle, the write goes to the copy that was visible before the exchange.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_byte_sel | input | 3 | Byte read code |
| rd_byte_data | output | 8 | Byte read data |
| rd_word_sel | input | 3 | Word read code |
| rd_word_data | output | 16 | Word read data |
| wr_en | input | 1 | Write strobe |
| wr_word | input | 1 | 1 = word write, 0 = byte write |
| wr_sel | input | 3 | Write code, byte or word coding according to wr_word |
| wr_data | input | 16 | Write data; byte writes use bits 7:0 |
| xchg_valid | input | 1 | Exchange opcode strobe |
| xchg_opcode | input | 8 | Opcode to decode for an exchange |

## Verification
The bench sweeps all 256 opcode values with the strobe high and reads back every word after each one. A decoder that matches extra codes, or that makes one opcode flip both selects, shows up as words changing when they should not. Writes made after an exchange are checked to land in the visible copy only. The bench then reverses the exchange and confirms the hidden copy was not touched. A design that wrote to the other copy, or copied data between banks, would return the wrong values at that point. Writes issued in the same cycle as an exchange are checked to land in the copy that was visible before the exchange, so a design that ordered the toggle ahead of the write would fail. Byte writes are checked against pair halves to catch swapped high and low halves.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam logic [2:0] BSEL_F = 3'd6;
    localparam logic [2:0] BSEL_A = 3'd7;

    localparam logic [2:0] WSEL_BC = 3'd0;
    localparam logic [2:0] WSEL_DE = 3'd1;
    localparam logic [2:0] WSEL_HL = 3'd2;
    localparam logic [2:0] WSEL_AF = 3'd3;
    localparam logic [2:0] WSEL_SP = 3'd4;
    localparam logic [2:0] WSEL_IX = 3'd5;
    localparam logic [2:0] WSEL_IY = 3'd6;

    localparam int unsigned NUM_PAIRS = 3;
    localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/rf_xchg_decode.sv
module rf_xchg_decode #(
    parameter int unsigned OPC_W   = 8,
    parameter logic [OPC_W-1:0] AF_OP   = 8'h08,
    parameter logic [OPC_W-1:0] MAIN_OP = 8'hD9
) (
    input  logic             valid,
    input  logic [OPC_W-1:0] opcode,
    output logic             tog_af,
    output logic             tog_main
);
    always_comb begin
        tog_af   = valid && (opcode == AF_OP);
        tog_main = valid && (opcode == MAIN_OP);
    end
endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux
    import rf_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned WORD_W = 2 * BYTE_W
) (
    input  logic [WORD_W-1:0]                af_vis,
    input  logic [NUM_PAIRS-1:0][WORD_W-1:0] pr_vis,
    input  logic [WORD_W-1:0]                sp,
    input  logic [WORD_W-1:0]                ix,
    input  logic [WORD_W-1:0]                iy,
    input  logic [2:0]                       byte_sel,
    input  logic [2:0]                       word_sel,
    output logic [BYTE_W-1:0]                byte_data,
    output logic [WORD_W-1:0]                word_data
);
    logic [7:0][BYTE_W-1:0] byte_view;

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair_bytes
        assign byte_view[2*g]   = pr_vis[g][WORD_W-1:BYTE_W];
        assign byte_view[2*g+1] = pr_vis[g][BYTE_W-1:0];
    end
    assign byte_view[BSEL_F] = af_vis[BYTE_W-1:0];
    assign byte_view[BSEL_A] = af_vis[WORD_W-1:BYTE_W];

    always_comb begin
        byte_data = byte_view[byte_sel];
        case (word_sel)
            WSEL_BC: word_data = pr_vis[0];
            WSEL_DE: word_data = pr_vis[1];
            WSEL_HL: word_data = pr_vis[2];
            WSEL_AF: word_data = af_vis;
            WSEL_SP: word_data = sp;
            WSEL_IX: word_data = ix;
            WSEL_IY: word_data = iy;
            default: word_data = '0;
        endcase
    end
endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile
    import rf_pkg::*;
#(
    parameter int unsigned BYTE_W  = 8,
    parameter int unsigned OPC_W   = 8,
    parameter logic [OPC_W-1:0] AF_OP   = 8'h08,
    parameter logic [OPC_W-1:0] MAIN_OP = 8'hD9,
    localparam int unsigned WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        rd_byte_sel,
    output logic [BYTE_W-1:0] rd_byte_data,
    input  logic [2:0]        rd_word_sel,
    output logic [WORD_W-1:0] rd_word_data,
    input  logic              wr_en,
    input  logic              wr_word,
    input  logic [2:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              xchg_valid,
    input  logic [OPC_W-1:0]  xchg_opcode
);
    typedef struct packed {
        logic                                    sel_af;
        logic                                    sel_main;
        logic [NUM_BANKS-1:0][WORD_W-1:0]        af;
        logic [NUM_BANKS-1:0][NUM_PAIRS-1:0][WORD_W-1:0] pr;
        logic [WORD_W-1:0]                       sp;
        logic [WORD_W-1:0]                       ix;
        logic [WORD_W-1:0]                       iy;
    } rf_state_t;

    rf_state_t st_d, st_q;
    logic      tog_af, tog_main;

    rf_xchg_decode #(
        .OPC_W  (OPC_W),
        .AF_OP  (AF_OP),
        .MAIN_OP(MAIN_OP)
    ) xdec_i (
        .valid   (xchg_valid),
        .opcode  (xchg_opcode),
        .tog_af  (tog_af),
        .tog_main(tog_main)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_word) begin
                case (wr_sel)
                    WSEL_BC, WSEL_DE, WSEL_HL:
                        st_d.pr[st_q.sel_main][wr_sel[1:0]] = wr_data;
                    WSEL_AF: st_d.af[st_q.sel_af] = wr_data;
                    WSEL_SP: st_d.sp = wr_data;
                    WSEL_IX: st_d.ix = wr_data;
                    WSEL_IY: st_d.iy = wr_data;
                    default: ;
                endcase
            end else if (wr_sel == BSEL_F) begin
                st_d.af[st_q.sel_af][BYTE_W-1:0] = wr_data[BYTE_W-1:0];
            end else if (wr_sel == BSEL_A) begin
                st_d.af[st_q.sel_af][WORD_W-1:BYTE_W] = wr_data[BYTE_W-1:0];
            end else if (wr_sel[0]) begin
                st_d.pr[st_q.sel_main][wr_sel[2:1]][BYTE_W-1:0] = wr_data[BYTE_W-1:0];
            end else begin
                st_d.pr[st_q.sel_main][wr_sel[2:1]][WORD_W-1:BYTE_W] = wr_data[BYTE_W-1:0];
            end
        end
        if (tog_af) begin
            st_d.sel_af = ~st_q.sel_af;
        end
        if (tog_main) begin
            st_d.sel_main = ~st_q.sel_main;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '1;
            st_q.sel_af   <= 1'b0;
            st_q.sel_main <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    rf_read_mux #(
        .BYTE_W(BYTE_W)
    ) rmux_i (
        .af_vis   (st_q.af[st_q.sel_af]),
        .pr_vis   (st_q.pr[st_q.sel_main]),
        .sp       (st_q.sp),
        .ix       (st_q.ix),
        .iy       (st_q.iy),
        .byte_sel (rd_byte_sel),
        .word_sel (rd_word_sel),
        .byte_data(rd_byte_data),
        .word_data(rd_word_data)
    );
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned OPC_W  = 8,
    parameter logic [OPC_W-1:0] AF_OP   = 8'h08,
    parameter logic [OPC_W-1:0] MAIN_OP = 8'hD9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xchg_valid,
    input logic [OPC_W-1:0]  xchg_opcode,
    input logic              wr_en,
    input logic              sel_af,
    input logic              sel_main,
    input logic [WORD_W-1:0] sp,
    input logic [WORD_W-1:0] ix,
    input logic [WORD_W-1:0] iy
);
    // R4: the accumulator/flags exchange flips its own select
    a_r4_af_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_valid && xchg_opcode == AF_OP) |=> (sel_af != $past(sel_af)));

    // R4: the accumulator/flags exchange leaves the other select alone
    a_r4_main_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_valid && xchg_opcode == AF_OP) |=> $stable(sel_main));

    // R5: the BC/DE/HL exchange flips its select and not the other one
    a_r5_main_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_valid && xchg_opcode == MAIN_OP) |=> (sel_main != $past(sel_main)) && $stable(sel_af));

    // R6: no exchange without a matching, strobed opcode
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(xchg_valid && (xchg_opcode == AF_OP || xchg_opcode == MAIN_OP))
        |=> $stable(sel_af) && $stable(sel_main));

    // R8: unbanked registers change only through a write
    a_r8_unbanked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sp) && $stable(ix) && $stable(iy));
endmodule

bind dual_bank_regfile rf_checker #(
    .WORD_W (WORD_W),
    .OPC_W  (OPC_W),
    .AF_OP  (AF_OP),
    .MAIN_OP(MAIN_OP)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .xchg_valid (xchg_valid),
    .xchg_opcode(xchg_opcode),
    .wr_en      (wr_en),
    .sel_af     (st_q.sel_af),
    .sel_main   (st_q.sel_main),
    .sp         (st_q.sp),
    .ix         (st_q.ix),
    .iy         (st_q.iy)
);

// File: tb/dual_bank_regfile_tb_top.sv
`timescale 1ns/1ps
module dual_bank_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rd_byte_sel = '0;
    logic [7:0]  rd_byte_data;
    logic [2:0]  rd_word_sel = '0;
    logic [15:0] rd_word_data;
    logic        wr_en = 1'b0;
    logic        wr_word = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        xchg_valid = 1'b0;
    logic [7:0]  xchg_opcode = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference copy of the architectural state
    logic [15:0] m_af [2];
    logic [15:0] m_pr [2][3];
    logic [15:0] m_sp, m_ix, m_iy;
    bit          m_saf, m_smain;

    always #2.5 clk = ~clk;

    dual_bank_regfile dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_byte_sel (rd_byte_sel),
        .rd_byte_data(rd_byte_data),
        .rd_word_sel (rd_word_sel),
        .rd_word_data(rd_word_data),
        .wr_en       (wr_en),
        .wr_word     (wr_word),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .xchg_valid  (xchg_valid),
        .xchg_opcode (xchg_opcode)
    );

    function automatic logic [15:0] exp_word(input int c);
        case (c)
            0, 1, 2: return m_pr[m_smain][c];
            3:       return m_af[m_saf];
            4:       return m_sp;
            5:       return m_ix;
            6:       return m_iy;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [7:0] exp_byte(input int c);
        logic [15:0] w;
        if (c >= 6) w = m_af[m_saf];
        else        w = m_pr[m_smain][c / 2];
        if (c == 6 || (c < 6 && c % 2 == 1)) return w[7:0];
        return w[15:8];
    endfunction

    task automatic check_all(input string req);
        for (int c = 0; c < 8; c++) begin
            rd_word_sel = c[2:0];
            rd_byte_sel = c[2:0];
            #0.5;
            checks++;
            if (rd_word_data !== exp_word(c)) begin
                fails++;
                $display("FAIL %s word code %0d: got %h expected %h", req, c, rd_word_data, exp_word(c));
            end
            checks++;
            if (rd_byte_data !== exp_byte(c)) begin
                fails++;
                $display("FAIL %s byte code %0d: got %h expected %h", req, c, rd_byte_data, exp_byte(c));
            end
        end
    endtask

    // one clock: optional write and optional exchange; model writes the
    // pre-exchange bank first, then flips the select (R9)
    task automatic cycle(input bit we, input bit wd, input int sel, input logic [15:0] data,
                         input bit xv, input logic [7:0] op);
        @(negedge clk);
        wr_en = we; wr_word = wd; wr_sel = sel[2:0]; wr_data = data;
        xchg_valid = xv; xchg_opcode = op;
        if (we) begin
            if (wd) begin
                case (sel)
                    0, 1, 2: m_pr[m_smain][sel] = data;
                    3: m_af[m_saf] = data;
                    4: m_sp = data;
                    5: m_ix = data;
                    6: m_iy = data;
                    default: ;
                endcase
            end else if (sel == 6) m_af[m_saf][7:0] = data[7:0];
            else if (sel == 7) m_af[m_saf][15:8] = data[7:0];
            else if (sel % 2 == 1) m_pr[m_smain][sel / 2][7:0] = data[7:0];
            else m_pr[m_smain][sel / 2][15:8] = data[7:0];
        end
        if (xv && op == 8'h08) m_saf = ~m_saf;
        if (xv && op == 8'hD9) m_smain = ~m_smain;
        @(posedge clk);
        #1;
        wr_en = 1'b0; xchg_valid = 1'b0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 2; b++) begin
            m_af[b] = 16'hFFFF;
            for (int p = 0; p < 3; p++) m_pr[b][p] = 16'hFFFF;
        end
        m_sp = 16'hFFFF; m_ix = 16'hFFFF; m_iy = 16'hFFFF;
        m_saf = 1'b0; m_smain = 1'b0;

        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 after release");

        // R3: word writes into the first banks and unbanked registers
        for (int c = 0; c < 8; c++) cycle(1, 1, c, 16'h1111 * (c + 1) + 16'h0A05, 0, 8'h00);
        check_all("R3 word write");

        // R2/R3: byte writes land on the right half
        for (int c = 0; c < 8; c++) begin
            cycle(1, 0, c, {8'hEE, 8'(8'h30 + c * 8'h11)}, 0, 8'h00);
            check_all("R2 byte write");
        end

        // R4 and R7: fill the alternate AF, then swap back
        cycle(0, 0, 0, 16'h0, 1, 8'h08);
        check_all("R4 af swap");
        cycle(1, 1, 3, 16'hA55A, 0, 8'h00);
        check_all("R7 alt af write");
        cycle(0, 0, 0, 16'h0, 1, 8'h08);
        check_all("R7 primary af kept");

        // R5 and R7: fill the alternate BC/DE/HL
        cycle(0, 0, 0, 16'h0, 1, 8'hD9);
        check_all("R5 main swap");
        for (int c = 0; c < 3; c++) cycle(1, 1, c, 16'hC0DE + 16'(c * 16'h0101), 0, 8'h00);
        cycle(1, 0, 3, 16'h0077, 0, 8'h00);
        check_all("R7 alt pair write");
        cycle(0, 0, 0, 16'h0, 1, 8'hD9);
        check_all("R7 primary pairs kept");

        // R6: matching opcode without strobe
        cycle(0, 0, 0, 16'h0, 0, 8'h08);
        cycle(0, 0, 0, 16'h0, 0, 8'hD9);
        check_all("R6 no strobe");

        // R4/R5/R6/R8: full opcode sweep
        for (int op = 0; op < 256; op++) begin
            cycle(0, 0, 0, 16'h0, 1, op[7:0]);
            check_all("R6 R8 opcode sweep");
        end

        // R9: write together with exchange
        cycle(1, 1, 2, 16'h9EAD, 1, 8'hD9);
        check_all("R9 pair write with swap");
        cycle(0, 0, 0, 16'h0, 1, 8'hD9);
        check_all("R9 pair write landed");
        cycle(1, 0, 7, 16'h005C, 1, 8'h08);
        check_all("R9 A write with swap");
        cycle(1, 1, 4, 16'h4242, 1, 8'h08);
        check_all("R8 R9 sp write with swap");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule